// File: doc/BRIEF.md
# Quad-Pumped Two-Write Two-Read Word Memory

This block gives its users two write ports and two read ports of full-width words in every system cycle, even though the storage underneath allows only one access at a time. To do this, the storage runs from a clock at four times the system rate. Each system cycle is cut into four fast slots. The slots serve, always in this sequence, write port A, write port B, read port A and read port B. The word is also wider than the native width of one storage lane, so the word is spread across several lanes. All lanes are accessed together in the same slot.

Everything inside the block runs on the fast clock. A strobe that lines up with the system clock edge marks the fast edge where a system cycle begins. At that edge the port inputs are captured, so they stay fixed for all four slots. The read results from those slots are then presented together, unchanged, for the whole next system cycle. Clock generation and crossing reset between the clock domains are handled outside the block.

Top module: `quad_pump_ram`

## Requirements
- R1: A 2-bit slot counter advances on every fast clock edge. The edge that ends slot 3 (encoding 3) is a system cycle boundary, so there are four slots in each system cycle. Inputs held during system cycle k appear on the read outputs throughout system cycle k+2.
- R2: Slots are served in a fixed sequence: slot 0 serves write A, slot 1 write B, slot 2 read A and slot 3 read B.
- R3: All port inputs are captured at the system cycle boundary. Changing them during the slots that follow has no effect on that cycle's accesses.
- R4: Writes come before reads, so a read of an address written in the same system cycle returns the newly written word.
- R5: When both write ports target the same address in one system cycle, the word from port B is the one kept.
- R6: A write port whose enable is low leaves memory unchanged, whatever its address and data inputs carry.
- R7: Both read outputs change only at the fast edge that ends slot 3. They then hold steady for the whole following system cycle.
- R8: Addresses are taken modulo DEPTH, so an address beyond the depth wraps onto a valid word.
- R9: When slotSync is sampled high at a fast edge, the inputs are captured at that edge and the next slot is slot 0. Read slots of the interrupted cycle that were not yet reached are abandoned, and the outputs keep their earlier values.
- R10: Reset puts the counter in slot 0, clears the captured enables, and drives both read outputs to zero.
- R11: A word of DATA_W bits is stored as DATA_W/LANE_W lanes that are written and read together in one slot. Full-width patterns round-trip intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fastClk | input | 1 | Clock at four times the system rate |
| rst | input | 1 | Synchronous active-high reset |
| slotSync | input | 1 | Marks the fast edge that starts a system cycle |
| wrEnA | input | 1 | Write enable, port A |
| wrAddrA | input | ADDR_W | Write address, port A |
| wrDataA | input | DATA_W | Write data, port A |
| wrEnB | input | 1 | Write enable, port B |
| wrAddrB | input | ADDR_W | Write address, port B |
| wrDataB | input | DATA_W | Write data, port B |
| rdAddrA | input | ADDR_W | Read address, port A |
| rdAddrB | input | ADDR_W | Read address, port B |
| rdDataA | output | DATA_W | Held read result, port A |
| rdDataB | output | DATA_W | Held read result, port B |

## Verification
The bench builds the block with DEPTH=16 and ADDR_W=8. Addresses such as 0x15 and 0x25 can then be used to show the modulo wrap, which the default depth of 256 with 8-bit addresses could never reach. LANE_W is set to 8, so each 32-bit word spans four lanes rather than two, and a lane that is not written or read along with the others would break the full-width patterns. One resync in the middle of a cycle, with read addresses different from those of the abandoned cycle, shows that slots which were never reached produce no output.

// File: rtl/qpr_pkg.sv
package qpr_pkg;

  // Slot encoding: position in the fixed write-write-read-read order.
  typedef enum logic [1:0] {
    SLOT_WR_A = 2'd0,
    SLOT_WR_B = 2'd1,
    SLOT_RD_A = 2'd2,
    SLOT_RD_B = 2'd3
  } slotT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic doCapture;   // capture port inputs at this edge
    slotT slot;        // slot being served now
    logic stageRd;     // latch read A result at this edge
    logic present;     // move both results to the outputs at this edge
  } slotCmdT;

endpackage

// File: rtl/qpr_ctrl.sv
module qpr_ctrl
  import qpr_pkg::*;
(
  input  logic    fastClk,
  input  logic    rst,
  input  logic    slotSync,
  output slotCmdT cmd
);

  slotT phase;

  always_ff @(posedge fastClk) begin
    if (rst) begin
      phase <= SLOT_WR_A;
    end else if (slotSync) begin
      phase <= SLOT_WR_A;
    end else begin
      phase <= slotT'(2'(phase + 2'd1));
    end
  end

  always_comb begin
    cmd.slot      = phase;
    cmd.doCapture = slotSync || (phase == SLOT_RD_B);
    cmd.stageRd   = (phase == SLOT_RD_A);
    cmd.present   = (phase == SLOT_RD_B);
  end

  AST_SYNC_TO_SLOT0: assert property (@(posedge fastClk) disable iff (rst)
    slotSync |=> (cmd.slot == SLOT_WR_A)); // R9

  AST_CAPTURE_STARTS_CYCLE: assert property (@(posedge fastClk) disable iff (rst)
    cmd.doCapture |=> (cmd.slot == SLOT_WR_A)); // R1

  AST_ORDER_WB: assert property (@(posedge fastClk) disable iff (rst)
    (cmd.slot == SLOT_WR_B) |-> ($past(cmd.slot) == SLOT_WR_A)); // R2

  AST_ORDER_RA: assert property (@(posedge fastClk) disable iff (rst)
    (cmd.slot == SLOT_RD_A) |-> ($past(cmd.slot) == SLOT_WR_B)); // R2

  AST_ORDER_RB: assert property (@(posedge fastClk) disable iff (rst)
    (cmd.slot == SLOT_RD_B) |-> ($past(cmd.slot) == SLOT_RD_A)); // R2

endmodule

// File: rtl/qpr_store.sv
module qpr_store #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 16,
  parameter int DEPTH  = 256,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int N_LANES = DATA_W / LANE_W
) (
  input  logic              fastClk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  // One single-access RAM per lane; every lane shares the slot's index.
  for (genvar l = 0; l < N_LANES; l++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge fastClk) begin
      if (we) begin
        laneMem[idx] <= wdata[l*LANE_W +: LANE_W];
      end
    end

    assign rdata[l*LANE_W +: LANE_W] = laneMem[idx];
  end

  initial begin
    assert (DATA_W % LANE_W == 0)
      else $error("DATA_W must be a multiple of LANE_W"); // R11
  end

endmodule

// File: rtl/qpr_dpath.sv
module qpr_dpath
  import qpr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 16,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              fastClk,
  input  logic              rst,
  input  slotCmdT           cmd,
  input  logic              wrEnA,
  input  logic [ADDR_W-1:0] wrAddrA,
  input  logic [DATA_W-1:0] wrDataA,
  input  logic              wrEnB,
  input  logic [ADDR_W-1:0] wrAddrB,
  input  logic [DATA_W-1:0] wrDataB,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  // Captured port set, held across the four slots.
  logic              capWeA, capWeB;
  logic [ADDR_W-1:0] capWrAddrA, capWrAddrB, capRdAddrA, capRdAddrB;
  logic [DATA_W-1:0] capWrDataA, capWrDataB;

  always_ff @(posedge fastClk) begin
    if (rst) begin
      capWeA     <= 1'b0;
      capWeB     <= 1'b0;
      capWrAddrA <= '0;
      capWrAddrB <= '0;
      capRdAddrA <= '0;
      capRdAddrB <= '0;
      capWrDataA <= '0;
      capWrDataB <= '0;
    end else if (cmd.doCapture) begin
      capWeA     <= wrEnA;
      capWeB     <= wrEnB;
      capWrAddrA <= wrAddrA;
      capWrAddrB <= wrAddrB;
      capRdAddrA <= rdAddrA;
      capRdAddrB <= rdAddrB;
      capWrDataA <= wrDataA;
      capWrDataB <= wrDataB;
    end
  end

  function automatic logic [IDX_W-1:0] wrapIdx(input logic [ADDR_W-1:0] a);
    return IDX_W'(32'(a) % DEPTH);
  endfunction

  // Slot access mux.
  logic              ramWe;
  logic [ADDR_W-1:0] ramAddr;
  logic [DATA_W-1:0] ramWdata;
  logic [DATA_W-1:0] ramRdata;

  always_comb begin
    ramWe    = 1'b0;
    ramWdata = '0;
    ramAddr  = '0;
    unique case (cmd.slot)
      SLOT_WR_A: begin
        ramWe    = capWeA;
        ramAddr  = capWrAddrA;
        ramWdata = capWrDataA;
      end
      SLOT_WR_B: begin
        ramWe    = capWeB;
        ramAddr  = capWrAddrB;
        ramWdata = capWrDataB;
      end
      SLOT_RD_A: ramAddr = capRdAddrA;
      SLOT_RD_B: ramAddr = capRdAddrB;
      default: ;
    endcase
  end

  qpr_store #(
    .DATA_W(DATA_W),
    .LANE_W(LANE_W),
    .DEPTH (DEPTH)
  ) uStore (
    .fastClk(fastClk),
    .we     (ramWe),
    .idx    (wrapIdx(ramAddr)),
    .wdata  (ramWdata),
    .rdata  (ramRdata)
  );

  // Read staging and output holding.
  logic [DATA_W-1:0] stageA;

  always_ff @(posedge fastClk) begin
    if (rst) begin
      stageA  <= '0;
      rdDataA <= '0;
      rdDataB <= '0;
    end else begin
      if (cmd.stageRd) begin
        stageA <= ramRdata;
      end
      if (cmd.present) begin
        rdDataA <= stageA;
        rdDataB <= ramRdata;
      end
    end
  end

  AST_HOLD_STEADY: assert property (@(posedge fastClk) disable iff (rst)
    !cmd.present |=> ($stable(rdDataA) && $stable(rdDataB))); // R7

  AST_CAPTURE_ONLY_AT_BOUNDARY: assert property (@(posedge fastClk) disable iff (rst)
    !cmd.doCapture |=> $stable({capWeA, capWeB, capWrAddrA, capWrAddrB,
                                capRdAddrA, capRdAddrB, capWrDataA, capWrDataB})); // R3

  AST_NO_WRITE_A_DISABLED: assert property (@(posedge fastClk) disable iff (rst)
    ((cmd.slot == SLOT_WR_A) && !capWeA) |-> !ramWe); // R6

  AST_NO_WRITE_IN_READ_SLOT: assert property (@(posedge fastClk) disable iff (rst)
    ((cmd.slot == SLOT_RD_A) || (cmd.slot == SLOT_RD_B)) |-> !ramWe); // R2

endmodule

// File: rtl/quad_pump_ram.sv
module quad_pump_ram
  import qpr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 16,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              fastClk,
  input  logic              rst,
  input  logic              slotSync,
  input  logic              wrEnA,
  input  logic [ADDR_W-1:0] wrAddrA,
  input  logic [DATA_W-1:0] wrDataA,
  input  logic              wrEnB,
  input  logic [ADDR_W-1:0] wrAddrB,
  input  logic [DATA_W-1:0] wrDataB,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  slotCmdT cmd;

  qpr_ctrl uCtrl (
    .fastClk (fastClk),
    .rst     (rst),
    .slotSync(slotSync),
    .cmd     (cmd)
  );

  qpr_dpath #(
    .DATA_W(DATA_W),
    .LANE_W(LANE_W),
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) uDpath (
    .fastClk(fastClk),
    .rst    (rst),
    .cmd    (cmd),
    .wrEnA  (wrEnA),
    .wrAddrA(wrAddrA),
    .wrDataA(wrDataA),
    .wrEnB  (wrEnB),
    .wrAddrB(wrAddrB),
    .wrDataB(wrDataB),
    .rdAddrA(rdAddrA),
    .rdAddrB(rdAddrB),
    .rdDataA(rdDataA),
    .rdDataB(rdDataB)
  );

endmodule

// File: tb/tb_quad_pump_ram.sv
module tb_quad_pump_ram;

  localparam int DATA_W = 32;
  localparam int LANE_W = 8;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 8;
  localparam int NVEC   = 8;

  logic              fastClk = 1'b0;
  logic              rst = 1'b1;
  logic              slotSync = 1'b0;
  logic              wrEnA = 1'b0, wrEnB = 1'b0;
  logic [ADDR_W-1:0] wrAddrA = '0, wrAddrB = '0, rdAddrA = '0, rdAddrB = '0;
  logic [DATA_W-1:0] wrDataA = '0, wrDataB = '0;
  logic [DATA_W-1:0] rdDataA, rdDataB;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 fastClk = ~fastClk;

  quad_pump_ram #(
    .DATA_W(DATA_W), .LANE_W(LANE_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) dut (
    .fastClk(fastClk), .rst(rst), .slotSync(slotSync),
    .wrEnA(wrEnA), .wrAddrA(wrAddrA), .wrDataA(wrDataA),
    .wrEnB(wrEnB), .wrAddrB(wrAddrB), .wrDataB(wrDataB),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

  typedef struct packed {
    logic              weA;
    logic [ADDR_W-1:0] adA;
    logic [DATA_W-1:0] dA;
    logic              weB;
    logic [ADDR_W-1:0] adB;
    logic [DATA_W-1:0] dB;
    logic [ADDR_W-1:0] raA;
    logic [ADDR_W-1:0] raB;
    logic [DATA_W-1:0] expA;
    logic [DATA_W-1:0] expB;
  } vecT;

  localparam vecT VECS [NVEC] = '{
    '{1'b1, 8'h01, 32'h11111111, 1'b1, 8'h02, 32'h22222222, 8'h01, 8'h02, 32'h11111111, 32'h22222222},
    '{1'b1, 8'h03, 32'h33333333, 1'b1, 8'h03, 32'h44444444, 8'h03, 8'h01, 32'h44444444, 32'h11111111},
    '{1'b0, 8'h01, 32'hdeadbeef, 1'b0, 8'h03, 32'hcafef00d, 8'h01, 8'h03, 32'h11111111, 32'h44444444},
    '{1'b1, 8'h15, 32'h55555555, 1'b0, 8'h05, 32'h00000000, 8'h05, 8'h25, 32'h55555555, 32'h55555555},
    '{1'b1, 8'h06, 32'h66666666, 1'b1, 8'h07, 32'h77777777, 8'h07, 8'h06, 32'h77777777, 32'h66666666},
    '{1'b1, 8'h02, 32'ha5a5a5a5, 1'b0, 8'h00, 32'h00000000, 8'h02, 8'h02, 32'ha5a5a5a5, 32'ha5a5a5a5},
    '{1'b0, 8'h08, 32'hffffffff, 1'b1, 8'h08, 32'h0badf00d, 8'h08, 8'h03, 32'h0badf00d, 32'h44444444},
    '{1'b1, 8'h01, 32'h12345678, 1'b0, 8'h00, 32'h00000000, 8'h01, 8'h05, 32'h12345678, 32'h55555555}
  };

  // Requirement each vector targets; every vector also relies on R1 latency.
  string tags [NVEC] = '{"R4 R11", "R5", "R6", "R8", "R2", "R1", "R6", "R3"};

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic weA, input logic [ADDR_W-1:0] adA, input logic [DATA_W-1:0] dA,
                       input logic weB, input logic [ADDR_W-1:0] adB, input logic [DATA_W-1:0] dB,
                       input logic [ADDR_W-1:0] raA, input logic [ADDR_W-1:0] raB);
    wrEnA = weA; wrAddrA = adA; wrDataA = dA;
    wrEnB = weB; wrAddrB = adB; wrDataB = dB;
    rdAddrA = raA; rdAddrB = raB;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge fastClk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    repeat (3) @(posedge fastClk);
    #1 rst = 1'b0;
    // R10: outputs cleared by reset
    check("R10 rdDataA", rdDataA, '0);
    check("R10 rdDataB", rdDataB, '0);

    // Align the system cycle: sync edge is boundary S0.
    @(negedge fastClk) slotSync = 1'b1;
    @(posedge fastClk);
    #1 slotSync = 1'b0;

    // Vector i driven after boundary Si, results visible after S(i+2).
    for (int i = 0; i < NVEC + 2; i++) begin
      if (i < NVEC)
        drive(VECS[i].weA, VECS[i].adA, VECS[i].dA, VECS[i].weB, VECS[i].adB,
              VECS[i].dB, VECS[i].raA, VECS[i].raB);
      else
        drive(1'b0, 8'h00, 32'h0, 1'b0, 8'h00, 32'h0, 8'h01, 8'h01);
      if (i >= 2) begin
        check({tags[i-2], " R1 port A"}, rdDataA, VECS[i-2].expA);
        check({tags[i-2], " R1 port B"}, rdDataB, VECS[i-2].expB);
      end
      repeat (2) @(posedge fastClk);
      #1;
      if (i >= 2) begin
        // R7: unchanged in mid-cycle
        check("R7 mid-cycle A", rdDataA, VECS[i-2].expA);
        check("R7 mid-cycle B", rdDataB, VECS[i-2].expB);
      end
      repeat (2) @(posedge fastClk);
      #1;
    end

    // Cycle whose reads (addr 2) will be abandoned by a resync.
    drive(1'b0, 8'h00, 32'h0, 1'b0, 8'h00, 32'h0, 8'h02, 8'h02);
    repeat (4) @(posedge fastClk);
    #1;
    check("R1 idle A", rdDataA, 32'h12345678);
    drive(1'b0, 8'h00, 32'h0, 1'b0, 8'h00, 32'h0, 8'h06, 8'h07);
    repeat (2) @(posedge fastClk);
    @(negedge fastClk) slotSync = 1'b1;
    @(posedge fastClk);
    #1 slotSync = 1'b0;
    check("R9 after sync A", rdDataA, 32'h12345678);
    @(posedge fastClk);
    #1;
    // R9: the old boundary edge passes without presenting addr 2
    check("R9 old boundary A", rdDataA, 32'h12345678);
    check("R9 old boundary B", rdDataB, 32'h12345678);
    repeat (3) @(posedge fastClk);
    #1;
    check("R9 new cycle A", rdDataA, 32'h66666666);
    check("R9 new cycle B", rdDataB, 32'h77777777);

    finish();
  end

endmodule